// File: doc/BRIEF.md
# Two-Step Best Path Metric Precompute for a 64-State Trellis Decoder

This block produces the purge threshold that a limited-search trellis decoder compares each new path metric against. It does not search the freshly updated metrics. Instead it builds the best (smallest) metric of step n ahead of time from the path metrics of step n-2 and the two branch-metric sets of steps n-1 and n. That takes the minimum search out of the add-compare-select feedback loop. A programmable offset is added to the result, and the sum leaves the block as the threshold for step n.

The 64 states fall into four residue classes by state index modulo 4, and the 16 branch metrics fall into four residue groups the same way. In the first pipeline stage, each class minimum is formed with two levels of 4-input comparators. Each class minimum is then added to a group minimum of step n-1, and two candidates are formed. They differ only in how classes 0 and 1 are paired with groups 0 and 1. In the second stage, the even-indexed and odd-indexed branch metrics of step n extend the two candidates. The smaller of the two results gets the offset added. Every metric is unsigned, and every addition clamps at the all-ones value.

Top module: `pm_thresh_precomp`

## Requirements
- R1: Path metric k (k = 0..63, lane k of pm_i at bits k*MW upward) belongs to class k mod 4. Branch metric g (g = 0..15, lane g of a branch-metric port) belongs to group g mod 4. Each class and each group enters the result only through its minimum.
- R2: Candidate A is the smallest of the four saturated sums (class c minimum + step n-1 group c minimum), c = 0..3.
- R3: Candidate B is the smallest of the four saturated sums in which class 0 takes group 1, class 1 takes group 0, class 2 takes group 2 and class 3 takes group 3.
- R4: The best metric is the smaller of two values. One is candidate A plus the minimum of the step n branch metrics with even index. The other is candidate B plus the minimum of those with odd index.
- R5: thr_o equals the best metric plus thr_i, where thr_i is sampled in the same cycle as bm_cur_i.
- R6: Every addition saturates at 2^MW-1 (1023 with the default MW=10) and never wraps.
- R7: A token presented with valid_i high in cycle c takes pm_i and bm_prev_i (step n-1) in cycle c. It takes bm_cur_i (step n) and thr_i in cycle c+1. valid_o is high in cycle c+2 with that token's threshold, and low in every other cycle.
- R8: While valid_o is low, thr_o keeps the last delivered threshold.
- R9: During reset, valid_o is 0 and thr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Token strobe for the step n-2 path metrics |
| pm_i | input | 64*MW | Path metrics of step n-2, lane k = state k |
| bm_prev_i | input | 16*MW | Branch metrics of step n-1, sampled with valid_i |
| bm_cur_i | input | 16*MW | Branch metrics of step n, sampled one cycle after valid_i |
| thr_i | input | MW | Threshold offset, sampled one cycle after valid_i |
| valid_o | output | 1 | Threshold valid |
| thr_o | output | MW | Purge threshold for step n |

## Verification
Under back-to-back tokens, the first stage captures a new token's step n-2 metrics and step n-1 branch minima in the same cycle that the second stage consumes the previous token's step n branch metrics and offset. The bench streams tokens with valid_i held high on consecutive cycles, and with random gaps, giving each token unrelated data. Each output is then judged against a brute-force minimum computed in the bench for exactly the token it belongs to. A mix-up in which cycle's branch metrics pair with which token shows up as a wrong value. Gap cycles are judged by requiring valid_o low with the previous threshold held.

// File: rtl/pmo_pkg.sv
package pmo_pkg;
  localparam int unsigned STATES   = 64;
  localparam int unsigned BRANCHES = 16;
  localparam int unsigned CLUSTERS = 4;
  localparam int unsigned CL_SIZE  = STATES / CLUSTERS;
  localparam int unsigned GR_SIZE  = BRANCHES / CLUSTERS;
  localparam int unsigned PAR_SIZE = BRANCHES / 2;
endpackage

// File: rtl/pmo_min4.sv
// 4-input minimum, ties resolve to the lower lane
module pmo_min4 #(
  parameter int unsigned W = 10
) (
  input  logic [3:0][W-1:0] d_i,
  output logic [W-1:0]      m_o
);
  logic [W-1:0] lo, hi;
  always_comb begin
    lo  = (d_i[1] < d_i[0]) ? d_i[1] : d_i[0];
    hi  = (d_i[3] < d_i[2]) ? d_i[3] : d_i[2];
    m_o = (hi < lo) ? hi : lo;
  end
endmodule

// File: rtl/pmo_sat_add.sv
module pmo_sat_add #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [W:0] sum;
  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    y_o = sum[W] ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/pmo_stage1.sv
// Stage 1: class minima of step n-2 metrics extended by step n-1 group minima
module pmo_stage1 import pmo_pkg::*; #(
  parameter int unsigned MW = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [STATES-1:0][MW-1:0]     pm_i,
  input  logic [BRANCHES-1:0][MW-1:0]   bm_i,
  output logic                          vld_o,
  output logic [MW-1:0]                 cand_a_o,
  output logic [MW-1:0]                 cand_b_o
);
  localparam int unsigned L1 = CL_SIZE / 4;

  logic [CLUSTERS-1:0][MW-1:0] cl_min, gr_min, sum_a, sum_b;
  logic [MW-1:0] cand_a_d, cand_b_d;

  for (genvar c = 0; c < CLUSTERS; c++) begin : g_cl
    localparam int unsigned SWP = (c < 2) ? (c ^ 1) : c;
    logic [L1-1:0][MW-1:0] lvl1;

    for (genvar q = 0; q < L1; q++) begin : g_l1
      pmo_min4 #(.W(MW)) u_l1 (
        .d_i({pm_i[CLUSTERS*(4*q+3)+c], pm_i[CLUSTERS*(4*q+2)+c],
              pm_i[CLUSTERS*(4*q+1)+c], pm_i[CLUSTERS*(4*q)+c]}),
        .m_o(lvl1[q])
      );
    end

    pmo_min4 #(.W(MW)) u_l2 (.d_i(lvl1), .m_o(cl_min[c]));

    pmo_min4 #(.W(MW)) u_gr (
      .d_i({bm_i[CLUSTERS*3+c], bm_i[CLUSTERS*2+c], bm_i[CLUSTERS+c], bm_i[c]}),
      .m_o(gr_min[c])
    );

    pmo_sat_add #(.W(MW)) u_sa (.a_i(cl_min[c]), .b_i(gr_min[c]),   .y_o(sum_a[c]));
    pmo_sat_add #(.W(MW)) u_sb (.a_i(cl_min[c]), .b_i(gr_min[SWP]), .y_o(sum_b[c]));
  end

  pmo_min4 #(.W(MW)) u_ca (.d_i(sum_a), .m_o(cand_a_d));
  pmo_min4 #(.W(MW)) u_cb (.d_i(sum_b), .m_o(cand_b_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      cand_a_o <= '0;
      cand_b_o <= '0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        cand_a_o <= cand_a_d;
        cand_b_o <= cand_b_d;
      end
    end
  end
endmodule

// File: rtl/pmo_stage2.sv
// Stage 2: extend candidates with step n parity minima, pick, add offset
module pmo_stage2 import pmo_pkg::*; #(
  parameter int unsigned MW = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vld_i,
  input  logic [MW-1:0]                 cand_a_i,
  input  logic [MW-1:0]                 cand_b_i,
  input  logic [BRANCHES-1:0][MW-1:0]   bm_i,
  input  logic [MW-1:0]                 thr_i,
  output logic                          vld_o,
  output logic [MW-1:0]                 thr_o
);
  logic [1:0][MW-1:0] cand, par_min, path;
  logic [MW-1:0] best, thr_d;

  assign cand = {cand_b_i, cand_a_i};

  // p = 0: even lanes, p = 1: odd lanes
  for (genvar p = 0; p < 2; p++) begin : g_par
    logic [1:0][MW-1:0] half;
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam int unsigned B = 8 * h + p;
      pmo_min4 #(.W(MW)) u_h (
        .d_i({bm_i[B+6], bm_i[B+4], bm_i[B+2], bm_i[B]}),
        .m_o(half[h])
      );
    end
    assign par_min[p] = (half[1] < half[0]) ? half[1] : half[0];
    pmo_sat_add #(.W(MW)) u_ext (.a_i(cand[p]), .b_i(par_min[p]), .y_o(path[p]));
  end

  assign best = (path[1] < path[0]) ? path[1] : path[0];

  pmo_sat_add #(.W(MW)) u_thr (.a_i(best), .b_i(thr_i), .y_o(thr_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      thr_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) thr_o <= thr_d;
    end
  end
endmodule

// File: rtl/pm_thresh_precomp.sv
module pm_thresh_precomp import pmo_pkg::*; #(
  parameter int unsigned MW = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [STATES*MW-1:0]   pm_i,
  input  logic [BRANCHES*MW-1:0] bm_prev_i,
  input  logic [BRANCHES*MW-1:0] bm_cur_i,
  input  logic [MW-1:0]          thr_i,
  output logic                   valid_o,
  output logic [MW-1:0]          thr_o
);
  logic [STATES-1:0][MW-1:0]   pm_arr;
  logic [BRANCHES-1:0][MW-1:0] bmp_arr, bmc_arr;
  logic          s1_vld;
  logic [MW-1:0] s1_cand_a, s1_cand_b;

  assign pm_arr  = pm_i;
  assign bmp_arr = bm_prev_i;
  assign bmc_arr = bm_cur_i;

  pmo_stage1 #(.MW(MW)) u_s1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .pm_i    (pm_arr),
    .bm_i    (bmp_arr),
    .vld_o   (s1_vld),
    .cand_a_o(s1_cand_a),
    .cand_b_o(s1_cand_b)
  );

  pmo_stage2 #(.MW(MW)) u_s2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .cand_a_i(s1_cand_a),
    .cand_b_i(s1_cand_b),
    .bm_i    (bmc_arr),
    .thr_i   (thr_i),
    .vld_o   (valid_o),
    .thr_o   (thr_o)
  );
endmodule

// File: rtl/pm_thresh_precomp_chk.sv
module pm_thresh_precomp_chk #(
  parameter int unsigned MW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [MW-1:0] thr_i,
  input logic          valid_o,
  input logic [MW-1:0] thr_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R9
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && thr_o == '0));

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && !valid_o) |-> $stable(thr_o));

  // R6
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && valid_o) |-> (thr_o >= $past(thr_i)));
endmodule

bind pm_thresh_precomp pm_thresh_precomp_chk #(.MW(MW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .thr_i  (thr_i),
  .valid_o(valid_o),
  .thr_o  (thr_o)
);

// File: tb/tb_pm_thresh_precomp.sv
module tb_pm_thresh_precomp;
  localparam int CLK_PERIOD = 10;
  localparam int MW   = 10;
  localparam int SAT  = (1 << MW) - 1;
  localparam int NS   = 64;
  localparam int NB   = 16;
  localparam int MAXT = 128;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic valid_i = 1'b0;
  logic [NS*MW-1:0] pm_i = '0;
  logic [NB*MW-1:0] bm_prev_i = '0;
  logic [NB*MW-1:0] bm_cur_i = '0;
  logic [MW-1:0] thr_i = '0;
  logic valid_o;
  logic [MW-1:0] thr_o;

  int checks = 0;
  int fails  = 0;
  int last_exp = 0;

  int pm_t[NS];
  int bmp_t[NB];
  int bmc_s[MAXT][NB];
  int thr_s[MAXT];
  int exp_s[MAXT];
  bit v_s[MAXT];

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_thresh_precomp #(.MW(MW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .pm_i(pm_i),
    .bm_prev_i(bm_prev_i), .bm_cur_i(bm_cur_i), .thr_i(thr_i),
    .valid_o(valid_o), .thr_o(thr_o)
  );

  function automatic int sat(int v);
    return (v > SAT) ? SAT : v;
  endfunction

  function automatic int swp(int c);
    return (c < 2) ? (c ^ 1) : c;
  endfunction

  // brute force over every (state, branch) pairing allowed by R1..R3
  function automatic int ref_thr(int t);
    int ca = SAT, cb = SAT, ev = SAT, od = SAT, r;
    for (int k = 0; k < NS; k++)
      for (int g = 0; g < NB; g++) begin
        if (g % 4 == k % 4 && sat(pm_t[k] + bmp_t[g]) < ca) ca = sat(pm_t[k] + bmp_t[g]);
        if (g % 4 == swp(k % 4) && sat(pm_t[k] + bmp_t[g]) < cb) cb = sat(pm_t[k] + bmp_t[g]);
      end
    for (int g = 0; g < NB; g++) begin
      if (g % 2 == 0 && bmc_s[t][g] < ev) ev = bmc_s[t][g];
      if (g % 2 == 1 && bmc_s[t][g] < od) od = bmc_s[t][g];
    end
    r = sat(ca + ev);
    if (sat(cb + od) < r) r = sat(cb + od);
    return sat(r + thr_s[t]);
  endfunction

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic gen(int mode, int t);
    v_s[t] = 1'b1;
    case (mode)
      0: begin
        for (int k = 0; k < NS; k++) pm_t[k] = 700;
        pm_t[t % NS] = 40 + (t % 7);
        for (int g = 0; g < NB; g++) begin bmp_t[g] = rnd(0, 300); bmc_s[t][g] = rnd(0, 300); end
        thr_s[t] = rnd(0, 200);
      end
      1: begin
        for (int k = 0; k < NS; k++) pm_t[k] = rnd(0, SAT);
        for (int g = 0; g < NB; g++) begin bmp_t[g] = rnd(0, SAT); bmc_s[t][g] = rnd(0, SAT); end
        thr_s[t] = rnd(0, SAT);
      end
      2: begin
        for (int k = 0; k < NS; k++) pm_t[k] = rnd(0, 255);
        for (int g = 0; g < NB; g++) begin bmp_t[g] = rnd(0, 63); bmc_s[t][g] = rnd(0, 63); end
        thr_s[t] = rnd(0, 63);
        v_s[t] = ($urandom % 2) == 1;
      end
      3: begin
        for (int k = 0; k < NS; k++) pm_t[k] = rnd(900, SAT);
        for (int g = 0; g < NB; g++) begin bmp_t[g] = rnd(100, SAT); bmc_s[t][g] = rnd(100, SAT); end
        thr_s[t] = rnd(500, SAT);
      end
      4: begin
        for (int k = 0; k < NS; k++) pm_t[k] = rnd(0, 400);
        for (int g = 0; g < NB; g++) bmp_t[g] = rnd(0, 100);
        for (int g = 0; g < NB; g++)
          bmc_s[t][g] = ((g % 2) == (t % 2)) ? rnd(600, 900) : rnd(0, 50);
        thr_s[t] = rnd(0, 100);
      end
      default: begin
        for (int k = 0; k < NS; k++) pm_t[k] = 0;
        for (int g = 0; g < NB; g++) begin bmp_t[g] = 0; bmc_s[t][g] = 0; end
        thr_s[t] = rnd(0, SAT);
      end
    endcase
    exp_s[t] = ref_thr(t);
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // token t: pm/bm_prev at step t, bm_cur/thr at step t+1, checked at step t+2
  task automatic run_stream(int mode, int n, string tag);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int t = i - 2;
        chk(valid_o == v_s[t], "R7", "valid_o", int'(valid_o), int'(v_s[t]));
        if (v_s[t]) begin
          chk(int'(thr_o) == exp_s[t], tag, "thr_o", int'(thr_o), exp_s[t]);
          last_exp = exp_s[t];
        end else begin
          chk(int'(thr_o) == last_exp, "R8", "held thr_o", int'(thr_o), last_exp);
        end
      end
      if (i >= 1 && i - 1 < n) begin
        for (int g = 0; g < NB; g++) bm_cur_i[g*MW +: MW] = MW'(bmc_s[i-1][g]);
        thr_i = MW'(thr_s[i-1]);
      end else begin
        bm_cur_i = '1;
        thr_i = '1;
      end
      if (i < n) begin
        gen(mode, i);
        for (int k = 0; k < NS; k++) pm_i[k*MW +: MW] = MW'(pm_t[k]);
        for (int g = 0; g < NB; g++) bm_prev_i[g*MW +: MW] = MW'(bmp_t[g]);
        valid_i = v_s[i];
      end else begin
        valid_i = 1'b0;
        pm_i = '1;
        bm_prev_i = '0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    chk(valid_o == 1'b0, "R9", "reset valid_o", int'(valid_o), 0);
    chk(thr_o == '0, "R9", "reset thr_o", int'(thr_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0, "R9", "idle valid_o", int'(valid_o), 0);
    run_stream(0, 64, "R1 R2 R3");   // single small metric swept over every state
    run_stream(5, 8,  "R5");         // zero metrics: threshold is the offset
    run_stream(4, 40, "R4");         // alternate which parity holds the small step n metrics
    run_stream(1, 60, "R2 R3 R4");   // full-range random, back to back
    run_stream(3, 30, "R6");         // sums driven past the ceiling
    run_stream(2, 80, "R7 R8");      // random gaps between tokens
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule